// File: doc/BRIEF.md
# PLL Feedback Multiplier Search Engine

This block picks an integer feedback multiplier for a clock synthesiser. When a start pulse arrives it captures a reference frequency and two target frequencies: one for the core clock and one for the microcontroller clock. It then works through the candidate multipliers one at a time. For each candidate it checks the oscillator frequency that would result. Next it derives the clock after the fixed divide-by-two. It then tries to find a core divisor that lands within a fixed tolerance of the core target. The first candidate that passes these checks wins. The block reports that multiplier, the core and microcontroller divisors, and the loop-filter and lock settings that belong to the multiplier.

All frequencies are unsigned 32-bit integers in kHz. Quotients and remainders come from one restoring divider that is shared and produces one quotient bit per cycle. The multiply is a single-cycle product. Software or a boot sequencer pulses start, waits for either done or error, and then copies the results into the clock-control registers.

Top module: `pll_fbdiv_search`

## Requirements
- R1: When start is accepted with a core target or microcontroller target of zero, the error flag rises on the next clock edge, busy never rises and no search takes place.
- R2: Candidates are tried from multiplier 125 down to 25, and the first candidate that passes every check is reported.
- R3: A candidate is considered only if multiplier × reference lies within 1 500 000 to 3 000 000 kHz, both limits included.
- R4: The divided clock is half the oscillator frequency, and a remainder from that halving rounds it up by 1 kHz.
- R5: Let q and r be the quotient and remainder of the divided clock over the core target. The core divisor is q when r < 10 000 kHz. Otherwise it is q+1 when target − r < 10 000 kHz. In all other cases the candidate is rejected.
- R6: A candidate whose core divisor would be above 63 is rejected.
- R7: The microcontroller divisor is the quotient of the divided clock over its target. It is raised by one when target − remainder < 10 000 kHz.
- R8: When no candidate passes, the error flag is raised and done stays low.
- R9: The reported multiplier selects its charge-pump code, resistor code and lock count from the fixed table. The filter code is always 3 and the lock window is always 63.
- R10: Start is ignored while busy; the run in progress finishes with the values captured at its own start.
- R11: After reset, and from done or error until the next accepted start, all result outputs hold steady. Done and error are never high together. Both are cleared, along with the results, when a start is accepted.
- R12: Take S as the edge that accepts start; the first candidate is evaluated at edge S+1. A candidate outside the window costs 1 cycle. A candidate rejected after division costs 34 cycles. An accepted candidate raises done 66 cycles after its evaluation edge. When the last candidate fails, error rises at that candidate's decision edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| ref_khz_i | input | 32 | Reference frequency, kHz |
| core_khz_i | input | 32 | Core target frequency, kHz |
| mcu_khz_i | input | 32 | Microcontroller target frequency, kHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | A candidate was found; results valid |
| err_o | output | 1 | Zero target or no candidate found |
| mult_o | output | 7 | Chosen feedback multiplier |
| core_div_o | output | 6 | Core clock divisor |
| mcu_div_o | output | 32 | Microcontroller clock divisor |
| cp_code_o | output | 4 | Charge-pump code |
| res_code_o | output | 4 | Loop-resistor code |
| lf_code_o | output | 2 | Loop-filter capacitor code |
| lock_cnt_o | output | 10 | Lock counter setting |
| lock_win_o | output | 7 | Lock window setting |

## Verification
Two events can land in the same cycle. A new start can arrive while the engine is busy. The divider can also finish its core division in the cycle where the microcontroller division has to be launched. The bench drives a second start with different operands in the middle of a search, and it still expects the result computed from the first operands. The bench also predicts, cycle by cycle, when busy, done and error should change, based on the per-candidate cost. Any lost or extra cycle when the core result is handed over to the microcontroller division therefore shows up as a mismatch on the exact clock where it happens.

// File: rtl/pll_search_pkg.sv
// Shared constants and types for the feedback multiplier search engine.
// Assumes all frequencies are unsigned integers in kHz.
package pll_search_pkg;
    parameter int          FREQ_W     = 32;
    parameter int          MULT_W     = 7;
    parameter int          CDIV_W     = 6;
    parameter int          MULT_LO    = 25;
    parameter int          MULT_HI    = 125;
    parameter longint      VCO_LO_KHZ = 1500000;
    parameter longint      VCO_HI_KHZ = 3000000;
    parameter int          TOL_KHZ    = 10000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_CORE = 2'd2,
        ST_MCU  = 2'd3
    } scan_state_t;

    typedef struct packed {
        logic [3:0] cp;
        logic [3:0] res;
        logic [1:0] lf;
        logic [9:0] lock_cnt;
        logic [6:0] lock_win;
    } loop_cfg_t;
endpackage

// File: rtl/pll_restoring_div.sv
// Restoring unsigned divider, one quotient bit per cycle.
// A start pulse captures the operands; done pulses W cycles later with
// quotient and remainder valid. Assumes divisor is nonzero at start.
module pll_restoring_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         done_o,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, dvs_q, dvd_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, done_q;
    logic [W:0]    trial;
    logic          fits;

    // Shift in the next dividend bit and test against the divisor.
    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        fits  = trial >= {1'b0, dvs_q};
    end

    // Operand capture and iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            dvd_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                rem_q <= '0;
                quo_q <= dividend_i;
                dvs_q <= divisor_i;
                dvd_q <= dividend_i;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? W'(trial - {1'b0, dvs_q}) : trial[W-1:0];
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign quot_o = quo_q;
    assign rem_o  = rem_q;

    p_div_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (({{W{1'b0}}, quo_q} * {{W{1'b0}}, dvs_q}) + {{W{1'b0}}, rem_q}
                    == {{W{1'b0}}, dvd_q}) && (rem_q < dvs_q));
    p_div_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> divisor_i != '0);
endmodule

// File: rtl/pll_loop_cfg.sv
// Loop-filter and lock settings selected by the feedback multiplier.
// Pure combinational; multipliers below the scan range map to the lowest row.
module pll_loop_cfg
    import pll_search_pkg::*;
#(
    parameter int M_W = MULT_W
) (
    input  logic [M_W-1:0] mult_i,
    output loop_cfg_t      cfg_o
);
    logic [31:0] m;
    assign m = 32'(mult_i);

    // Charge-pump and resistor codes by multiplier band.
    always_comb begin
        cfg_o.lf       = 2'd3;
        cfg_o.lock_win = 7'd63;
        if      (m <= 32'd26)  begin cfg_o.cp = 4'd3; cfg_o.res = 4'd10; end
        else if (m <= 32'd30)  begin cfg_o.cp = 4'd4; cfg_o.res = 4'd6;  end
        else if (m <= 32'd32)  begin cfg_o.cp = 4'd6; cfg_o.res = 4'd1;  end
        else if (m == 32'd33)  begin cfg_o.cp = 4'd4; cfg_o.res = 4'd10; end
        else if (m <= 32'd38)  begin cfg_o.cp = 4'd5; cfg_o.res = 4'd6;  end
        else if (m <= 32'd50)  begin cfg_o.cp = 4'd3; cfg_o.res = 4'd12; end
        else if (m <= 32'd82)  begin cfg_o.cp = 4'd3; cfg_o.res = 4'd2;  end
        else if (m <= 32'd102) begin cfg_o.cp = 4'd4; cfg_o.res = 4'd2;  end
        else if (m <= 32'd106) begin cfg_o.cp = 4'd5; cfg_o.res = 4'd2;  end
        else                   begin cfg_o.cp = 4'd3; cfg_o.res = 4'd4;  end

        if      (m <= 32'd37) cfg_o.lock_cnt = 10'd1000;
        else if (m >= 32'd61) cfg_o.lock_cnt = 10'd600;
        else if (m <= 32'd42) cfg_o.lock_cnt = 10'(32'd1000 - 32'd25 * (m - 32'd37));
        else if (m <= 32'd44) cfg_o.lock_cnt = 10'd850;
        else if (m == 32'd45) cfg_o.lock_cnt = 10'd825;
        else if (m == 32'd46) cfg_o.lock_cnt = 10'd800;
        else if (m <= 32'd48) cfg_o.lock_cnt = 10'd775;
        else if (m <= 32'd50) cfg_o.lock_cnt = 10'd750;
        else if (m == 32'd51) cfg_o.lock_cnt = 10'd725;
        else if (m <= 32'd53) cfg_o.lock_cnt = 10'd700;
        else if (m <= 32'd55) cfg_o.lock_cnt = 10'd675;
        else if (m <= 32'd57) cfg_o.lock_cnt = 10'd650;
        else                  cfg_o.lock_cnt = 10'd625;
    end
endmodule

// File: rtl/pll_fbdiv_search.sv
// Feedback multiplier search engine. On start it scans multipliers from the
// top of the range downward, checking the oscillator window and the core
// divisor tolerance, then derives the microcontroller divisor.
// Assumes operands are stable only at the accepting start edge.
module pll_fbdiv_search
    import pll_search_pkg::*;
#(
    parameter int FW = FREQ_W,
    parameter int MW = MULT_W,
    parameter int DW = CDIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [FW-1:0] ref_khz_i,
    input  logic [FW-1:0] core_khz_i,
    input  logic [FW-1:0] mcu_khz_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic [MW-1:0] mult_o,
    output logic [DW-1:0] core_div_o,
    output logic [FW-1:0] mcu_div_o,
    output logic [3:0]    cp_code_o,
    output logic [3:0]    res_code_o,
    output logic [1:0]    lf_code_o,
    output logic [9:0]    lock_cnt_o,
    output logic [6:0]    lock_win_o
);
    localparam int          VW    = FW + MW;
    localparam logic [VW-1:0] V_LO = VW'(VCO_LO_KHZ);
    localparam logic [VW-1:0] V_HI = VW'(VCO_HI_KHZ);
    localparam logic [FW-1:0] TOL  = FW'(TOL_KHZ);
    localparam logic [FW:0]   DMAX = (FW+1)'((1 << DW) - 1);

    scan_state_t   st_q;
    logic [MW-1:0] mult_q, res_mult_q;
    logic [FW-1:0] ref_q, core_q, mcu_q, pll_q, mcu_div_q;
    logic [VW-1:0] vco_q, vco_w;
    logic [DW-1:0] core_div_q;
    logic          busy_q, done_q, err_q;
    logic          in_win, last_cand, rnd_dn, rnd_up, core_ok;
    logic [FW-1:0] pll_w, mcu_div_w;
    logic [FW:0]   cand;
    logic          div_start, div_done;
    logic [FW-1:0] div_dvd, div_dvs, div_quo, div_rem;
    loop_cfg_t     cfg;

    // Oscillator frequency of the current candidate and its halved clock.
    always_comb begin
        vco_w     = VW'(mult_q) * VW'(ref_q);
        in_win    = (vco_w >= V_LO) && (vco_w <= V_HI);
        pll_w     = FW'((vco_w + VW'(1)) >> 1);
        last_cand = mult_q == MW'(MULT_LO);
    end

    // Core divisor with round-down preferred over round-up, then range check.
    always_comb begin
        rnd_dn    = div_rem < TOL;
        rnd_up    = (core_q - div_rem) < TOL;
        cand      = {1'b0, div_quo} + ((rnd_dn) ? '0 : (FW+1)'(1));
        core_ok   = (rnd_dn || rnd_up) && (cand <= DMAX);
        mcu_div_w = div_quo + (((mcu_q - div_rem) < TOL) ? FW'(1) : FW'(0));
    end

    // Divider operand routing: core division from scan, then MCU division.
    always_comb begin
        div_start = 1'b0;
        div_dvd   = pll_w;
        div_dvs   = core_q;
        if (st_q == ST_SCAN) begin
            div_start = in_win;
        end else if (st_q == ST_CORE) begin
            div_start = div_done && core_ok;
            div_dvd   = pll_q;
            div_dvs   = mcu_q;
        end
    end

    pll_restoring_div #(.W(FW)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (div_dvd),
        .divisor_i  (div_dvs),
        .done_o     (div_done),
        .quot_o     (div_quo),
        .rem_o      (div_rem)
    );

    // Search sequencer: capture, scan, evaluate, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            mult_q     <= MW'(MULT_HI);
            res_mult_q <= '0;
            ref_q      <= '0;
            core_q     <= '0;
            mcu_q      <= '0;
            pll_q      <= '0;
            vco_q      <= '0;
            core_div_q <= '0;
            mcu_div_q  <= '0;
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start_i) begin
                    done_q     <= 1'b0;
                    res_mult_q <= '0;
                    core_div_q <= '0;
                    mcu_div_q  <= '0;
                    if (core_khz_i == '0 || mcu_khz_i == '0) begin
                        err_q <= 1'b1;
                    end else begin
                        err_q  <= 1'b0;
                        busy_q <= 1'b1;
                        st_q   <= ST_SCAN;
                        mult_q <= MW'(MULT_HI);
                        ref_q  <= ref_khz_i;
                        core_q <= core_khz_i;
                        mcu_q  <= mcu_khz_i;
                    end
                end
                ST_SCAN: begin
                    if (in_win) begin
                        vco_q <= vco_w;
                        pll_q <= pll_w;
                        st_q  <= ST_CORE;
                    end else if (last_cand) begin
                        err_q  <= 1'b1;
                        busy_q <= 1'b0;
                        st_q   <= ST_IDLE;
                    end else begin
                        mult_q <= mult_q - MW'(1);
                    end
                end
                ST_CORE: if (div_done) begin
                    if (core_ok) begin
                        core_div_q <= cand[DW-1:0];
                        st_q       <= ST_MCU;
                    end else if (last_cand) begin
                        err_q  <= 1'b1;
                        busy_q <= 1'b0;
                        st_q   <= ST_IDLE;
                    end else begin
                        mult_q <= mult_q - MW'(1);
                        st_q   <= ST_SCAN;
                    end
                end
                ST_MCU: if (div_done) begin
                    mcu_div_q  <= mcu_div_w;
                    res_mult_q <= mult_q;
                    done_q     <= 1'b1;
                    busy_q     <= 1'b0;
                    st_q       <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    pll_loop_cfg #(.M_W(MW)) u_cfg (
        .mult_i (res_mult_q),
        .cfg_o  (cfg)
    );

    assign busy_o     = busy_q;
    assign done_o     = done_q;
    assign err_o      = err_q;
    assign mult_o     = res_mult_q;
    assign core_div_o = core_div_q;
    assign mcu_div_o  = mcu_div_q;
    assign cp_code_o  = cfg.cp;
    assign res_code_o = cfg.res;
    assign lf_code_o  = cfg.lf;
    assign lock_cnt_o = cfg.lock_cnt;
    assign lock_win_o = cfg.lock_win;

    p_zero_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (core_khz_i == '0 || mcu_khz_i == '0) |=> err_o && !busy_o);
    p_mult_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (mult_q >= MW'(MULT_LO)) && (mult_q <= MW'(MULT_HI)));
    p_scan_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) |-> mult_q <= $past(mult_q));
    p_vco_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (vco_q >= V_LO) && (vco_q <= V_HI));
    p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> $stable(ref_q) && $stable(core_q) && $stable(mcu_q));
    p_excl_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));
    p_hold_results_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) && !start_i |=> $stable(mult_o) && $stable(core_div_o)
            && $stable(mcu_div_o) && $stable(done_o) && $stable(err_o));
endmodule

// File: tb/pll_fbdiv_search_bench.sv
`timescale 1ns/1ps
module pll_fbdiv_search_bench;
    localparam int DIV_CYC = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] ref_khz_i = '0, core_khz_i = '0, mcu_khz_i = '0;
    logic        busy_o, done_o, err_o;
    logic [6:0]  mult_o;
    logic [5:0]  core_div_o;
    logic [31:0] mcu_div_o;
    logic [3:0]  cp_code_o, res_code_o;
    logic [1:0]  lf_code_o;
    logic [9:0]  lock_cnt_o;
    logic [6:0]  lock_win_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pll_fbdiv_search u_pll_fbdiv_search (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .ref_khz_i(ref_khz_i), .core_khz_i(core_khz_i), .mcu_khz_i(mcu_khz_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .mult_o(mult_o), .core_div_o(core_div_o), .mcu_div_o(mcu_div_o),
        .cp_code_o(cp_code_o), .res_code_o(res_code_o), .lf_code_o(lf_code_o),
        .lock_cnt_o(lock_cnt_o), .lock_win_o(lock_win_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Expected table values, written as per-multiplier ranges.
    function automatic void exp_cfg(input int m, output int cp, output int rs, output int lk);
        cp = 3; rs = 4;
        if (m >= 25 && m <= 26) begin cp = 3; rs = 10; end
        if (m >= 27 && m <= 30) begin cp = 4; rs = 6; end
        if (m >= 31 && m <= 32) begin cp = 6; rs = 1; end
        if (m == 33)            begin cp = 4; rs = 10; end
        if (m >= 34 && m <= 38) begin cp = 5; rs = 6; end
        if (m >= 39 && m <= 50) begin cp = 3; rs = 12; end
        if (m >= 51 && m <= 82) begin cp = 3; rs = 2; end
        if (m >= 83 && m <= 102) begin cp = 4; rs = 2; end
        if (m >= 103 && m <= 106) begin cp = 5; rs = 2; end
        case (m)
            38: lk = 975; 39: lk = 950; 40: lk = 925; 41: lk = 900; 42: lk = 875;
            43, 44: lk = 850; 45: lk = 825; 46: lk = 800; 47, 48: lk = 775;
            49, 50: lk = 750; 51: lk = 725; 52, 53: lk = 700; 54, 55: lk = 675;
            56, 57: lk = 650; 58, 59, 60: lk = 625;
            default: lk = (m < 38) ? 1000 : 600;
        endcase
    endfunction

    // Behavioural model: result and the edge count to completion.
    task automatic model(input longint rf, input longint cr, input longint mc,
                         output bit ok, output int m_sel, output longint cd,
                         output longint md, output int fin);
        int p = 1;
        ok = 0; m_sel = 0; cd = 0; md = 0; fin = 0;
        if (cr == 0 || mc == 0) return;
        for (int m = 125; m >= 25; m--) begin
            longint vco = m * rf;
            longint pll, q, r, c;
            if (vco < 1500000 || vco > 3000000) begin
                if (m == 25) begin fin = p; return; end
                p += 1;
                continue;
            end
            pll = (vco + 1) / 2;
            q = pll / cr; r = pll % cr;
            if (r < 10000) c = q;
            else if (cr - r < 10000) c = q + 1;
            else c = -1;
            if (c >= 0 && c <= 63) begin
                ok = 1; m_sel = m; cd = c;
                md = pll / mc + (((mc - (pll % mc)) < 10000) ? 1 : 0);
                fin = p + 2 * DIV_CYC + 2;
                return;
            end
            if (m == 25) begin fin = p + DIV_CYC + 1; return; end
            p += DIV_CYC + 2;
        end
    endtask

    // One search, compared against the model on every clock (R12).
    task automatic run(input string tag, input longint rf, input longint cr,
                       input longint mc, input bit inject);
        bit ok; int ms, fin, cp, rs, lk; longint cd, md;
        model(rf, cr, mc, ok, ms, cd, md, fin);
        @(negedge clk);
        start_i = 1'b1; ref_khz_i = 32'(rf); core_khz_i = 32'(cr); mcu_khz_i = 32'(mc);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k <= fin; k++) begin
            if (k > 0) @(negedge clk);
            start_i = 1'b0;
            if (k < fin)
                chk({tag, " R12 busy/done/err mid-run"}, {busy_o, done_o, err_o}, 3'b100);
            else
                chk({tag, " R12 busy/done/err at end"}, {busy_o, done_o, err_o},
                    {1'b0, ok, !ok});
            if (inject && k == 4) begin
                start_i = 1'b1; ref_khz_i = 32'd50000; core_khz_i = 32'd1; mcu_khz_i = 32'd1;
            end
        end
        if (ok) begin
            exp_cfg(ms, cp, rs, lk);
            chk({tag, " R2 multiplier"}, mult_o, ms);
            chk({tag, " R5 core divisor"}, core_div_o, cd);
            chk({tag, " R7 mcu divisor"}, mcu_div_o, md);
            chk({tag, " R9 charge pump"}, cp_code_o, cp);
            chk({tag, " R9 resistor"}, res_code_o, rs);
            chk({tag, " R9 lock count"}, lock_cnt_o, lk);
            chk({tag, " R9 filter/window"}, {lf_code_o, lock_win_o}, {2'd3, 7'd63});
        end else begin
            chk({tag, " R8 results cleared"}, {mult_o, core_div_o, mcu_div_o}, 0);
        end
    endtask

    // Outputs must not move while idle after a finished run (R11).
    task automatic hold(input string tag, input int n);
        logic [47:0] snap = {done_o, err_o, mult_o, core_div_o, mcu_div_o};
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk({tag, " R11 hold"}, {done_o, err_o, mult_o, core_div_o, mcu_div_o}, snap);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset R11 flags", {busy_o, done_o, err_o}, 0);
        chk("reset R11 results", {mult_o, core_div_o, mcu_div_o}, 0);

        run("basic R2 R3", 25000, 100000, 50000, 0);
        hold("basic", 6);
        run("zero core R1", 25000, 0, 50000, 0);
        run("zero mcu R1", 25000, 100000, 0, 0);
        hold("zero", 4);
        run("none in window R8", 10000, 100000, 50000, 0);
        run("low edge R3", 12000, 75000, 75000, 0);
        run("high edge R3", 24000, 100000, 100000, 0);
        run("halving round-up R4", 12001, 740063, 100000, 0);
        run("round up R5 R7", 24000, 150100, 150100, 0);
        run("remainder at tolerance R5", 24000, 1490000, 100000, 0);
        run("divisor 64 rejected R6", 24000, 23500, 50000, 0);
        run("divisor 63 kept R6", 24000, 23810, 50000, 0);
        run("table m50 R9", 60000, 100000, 33000, 0);
        run("table m52 R9", 57000, 114000, 57000, 0);
        run("table m30 R9", 100000, 100000, 300000, 0);
        run("table m25 R9", 120000, 100000, 100000, 0);
        run("start while busy R10", 25000, 100000, 50000, 1);
        hold("after ignored start", 6);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R12 actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule